// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions that a dynamically scheduled core issues and then executes out of order. Each issued instruction gets a slot at the tail of a circular buffer. The slot number is handed back as the instruction's tag. Execution units report results in any order by writing to the slot that the tag names. The buffer releases instructions one at a time, oldest first. Releasing an instruction is the only moment its result may reach architectural state.

Faults and branch redirects act only when the offending instruction is the oldest one in the buffer, so state stays precise. If the oldest completed slot carries a fault, the buffer reports the fault with that slot's tag, retires nothing, and discards every slot. If the oldest completed slot is a branch flagged as mispredicted, the branch retires and every younger slot is discarded. Both cases raise the flush output for one cycle. The core uses that cycle to redirect fetch.

Top module: `rob`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, `full` is 0, and `ret_valid`, `flush` and `flush_exc` are 0.
- R2: An accepted issue (`iss_valid` and `iss_ready` high at a clock edge) takes the slot given by `iss_tag`. The next issue then gets the following slot number, and slot 7 is followed by slot 0.
- R3: With 8 slots outstanding, `full` is 1 and `iss_ready` is 0. An issue request in that state allocates nothing. At most one allocation and at most one retirement happen per cycle.
- R4: A completion (`cmp_valid`) to an outstanding slot records the value and the fault and mispredict flags. Completions may arrive in any order, and a completed slot does not retire while any older slot is still incomplete.
- R5: When the oldest slot is complete and has no fault, `ret_valid` is 1 in that cycle. `ret_tag`, `ret_kind`, `ret_dest` and `ret_value` then show that slot's contents, and the slot is released at the clock edge.
- R6: A completion whose tag names a slot that is not outstanding has no effect.
- R7: When the oldest slot is complete with its fault flag set, `flush_exc` and `flush` are 1 and `flush_tag` gives that slot's tag. `ret_valid` is 0, all slots are discarded, and the next issue reuses that same tag.
- R8: When the oldest slot is complete, has kind 3 (branch) and has its mispredict flag set, it retires with `ret_valid` = 1 and `flush` = 1 while `flush_exc` stays 0. All younger slots are discarded, and the next issue gets the branch's tag plus one.
- R9: Slots younger than a faulting slot never retire, even if they completed before it.
- R10: In a flush cycle `iss_ready` is 0 and an issue request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Instruction kind (0 ALU, 1 load, 2 store, 3 branch) |
| iss_dest | input | 5 | Destination register number |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_tag | output | 3 | Tag that the current issue request receives |
| full | output | 1 | All slots are outstanding |
| cmp_valid | input | 1 | Completion write |
| cmp_tag | input | 3 | Slot being completed |
| cmp_value | input | 32 | Result value |
| cmp_exc | input | 1 | Instruction raised a fault |
| cmp_mispred | input | 1 | Branch was mispredicted |
| ret_valid | output | 1 | Oldest slot retires this cycle |
| ret_tag | output | 3 | Tag of the retiring slot |
| ret_kind | output | 2 | Kind of the retiring slot |
| ret_dest | output | 5 | Destination of the retiring slot |
| ret_value | output | 32 | Result of the retiring slot |
| flush | output | 1 | Discard speculative slots this cycle |
| flush_exc | output | 1 | The flush is caused by a fault |
| flush_tag | output | 3 | Tag of the oldest slot at the flush |

## Verification
The embedded assertions check on every cycle that the occupancy count agrees with the number of outstanding slots and never exceeds the depth. They also check that each retirement advances the oldest pointer by one, that a flush leaves the buffer empty, and that a fault flush rewinds the allocation pointer to the faulting slot. The bench's scenarios are needed to show the rest. These are out-of-order completion held behind an older incomplete slot, completions to stale tags being ignored, pointer wrap after a full buffer, younger completed work being dropped behind a fault, and the tag handed out right after each kind of flush.

// File: rtl/rob.sv
module rob #(
  parameter int DEPTH       = 8,
  parameter int DATA_W      = 32,
  parameter int DEST_W      = 5,
  parameter int KIND_W      = 2,
  parameter int BRANCH_KIND = 3,
  localparam int TAG_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [KIND_W-1:0] iss_kind,
  input  logic [DEST_W-1:0] iss_dest,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              full,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_exc,
  input  logic              cmp_mispred,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [KIND_W-1:0] ret_kind,
  output logic [DEST_W-1:0] ret_dest,
  output logic [DATA_W-1:0] ret_value,
  output logic              flush,
  output logic              flush_exc,
  output logic [TAG_W-1:0]  flush_tag
);

  logic [DEPTH-1:0]  busy, done, exc, mis;
  logic [KIND_W-1:0] kind_q [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  logic head_done, mis_flush, alloc, cmp_ok;

  assign head_done = busy[head] && done[head];
  assign flush_exc = head_done && exc[head];
  assign ret_valid = head_done && !exc[head];
  assign mis_flush = ret_valid && mis[head] && (int'(kind_q[head]) == BRANCH_KIND);
  assign flush     = flush_exc || mis_flush;
  assign full      = (cnt == CNT_W'(DEPTH));
  assign iss_ready = !full && !flush;
  assign iss_tag   = tail;
  assign flush_tag = head;
  assign ret_tag   = head;
  assign ret_kind  = kind_q[head];
  assign ret_dest  = dest_q[head];
  assign ret_value = val_q[head];
  assign alloc     = iss_valid && iss_ready;
  assign cmp_ok    = cmp_valid && (int'(cmp_tag) < DEPTH) && busy[cmp_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      done <= '0;
      exc  <= '0;
      mis  <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (cmp_ok) begin
        done[cmp_tag]  <= 1'b1;
        exc[cmp_tag]   <= cmp_exc;
        mis[cmp_tag]   <= cmp_mispred;
        val_q[cmp_tag] <= cmp_value;
      end
      if (flush) begin
        busy <= '0;
        cnt  <= '0;
        if (mis_flush) begin
          head <= nxt(head);
          tail <= nxt(head);
        end else begin
          tail <= head;
        end
      end else begin
        if (alloc) begin
          busy[tail]   <= 1'b1;
          done[tail]   <= 1'b0;
          exc[tail]    <= 1'b0;
          mis[tail]    <= 1'b0;
          kind_q[tail] <= iss_kind;
          dest_q[tail] <= iss_dest;
          tail         <= nxt(tail);
        end
        if (ret_valid) begin
          busy[head] <= 1'b0;
          head       <= nxt(head);
        end
        cnt <= cnt + CNT_W'(alloc) - CNT_W'(ret_valid);
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  a_r3_count_matches_busy: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'($countones(busy)) == cnt);

  a_r5_head_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> head == nxt($past(head)));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0) && (busy == '0));

  a_r7_tail_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exc |=> tail == $past(head));

  a_r8_tail_past_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !flush_exc) |=> tail == nxt($past(head)));

endmodule

// File: tb/test_rob.sv
`timescale 1ns/1ps
module test_rob;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic [1:0]  iss_kind;
  logic [4:0]  iss_dest;
  logic        iss_ready;
  logic [2:0]  iss_tag;
  logic        full;
  logic        cmp_valid;
  logic [2:0]  cmp_tag;
  logic [31:0] cmp_value;
  logic        cmp_exc, cmp_mispred;
  logic        ret_valid;
  logic [2:0]  ret_tag;
  logic [1:0]  ret_kind;
  logic [4:0]  ret_dest;
  logic [31:0] ret_value;
  logic        flush, flush_exc;
  logic [2:0]  flush_tag;

  always #2.5 clk = ~clk;

  rob i_rob (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dest(iss_dest),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .full(full),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .cmp_exc(cmp_exc), .cmp_mispred(cmp_mispred),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_kind(ret_kind),
    .ret_dest(ret_dest), .ret_value(ret_value),
    .flush(flush), .flush_exc(flush_exc), .flush_tag(flush_tag)
  );

  typedef struct {
    int tag; int kind; int dest; int val;
    bit done; bit exc; bit mis;
  } ent_t;

  ent_t q[$];
  int   tail_m = 0;
  int   vectors = 0;
  int   miscompares = 0;

  task automatic chk(string req, string name, longint act, longint exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic step(bit iv, int k, int d, bit cv, int ct, int cval, bit ce, bit cm);
    bit hd, e_exc, e_ret, e_mis, e_fl, e_full, e_ready;
    int htag;
    iss_valid = iv; iss_kind = 2'(k); iss_dest = 5'(d);
    cmp_valid = cv; cmp_tag = 3'(ct); cmp_value = cval;
    cmp_exc = ce; cmp_mispred = cm;
    #1;
    hd      = (q.size() > 0) && q[0].done;
    e_exc   = hd && q[0].exc;
    e_ret   = hd && !q[0].exc;
    e_mis   = e_ret && q[0].mis && (q[0].kind == 3);
    e_fl    = e_exc || e_mis;
    e_full  = (q.size() == 8);
    e_ready = !e_full && !e_fl;
    htag    = (q.size() > 0) ? q[0].tag : 0;
    vectors++;
    chk("R3 R10", "iss_ready", iss_ready, e_ready);
    chk("R3", "full", full, e_full);
    chk("R2", "iss_tag", iss_tag, tail_m);
    chk("R4 R5 R9", "ret_valid", ret_valid, e_ret);
    if (e_ret) begin
      chk("R5", "ret_tag", ret_tag, q[0].tag);
      chk("R5", "ret_kind", ret_kind, q[0].kind);
      chk("R5", "ret_dest", ret_dest, q[0].dest);
      chk("R5", "ret_value", ret_value, q[0].val);
    end
    chk("R7", "flush_exc", flush_exc, e_exc);
    chk("R8", "flush", flush, e_fl);
    if (e_exc) chk("R7", "flush_tag", flush_tag, htag);
    if (cv) foreach (q[i]) if (q[i].tag == ct) begin
      q[i].done = 1'b1; q[i].exc = ce; q[i].mis = cm; q[i].val = cval;
    end
    if (e_fl) begin
      q.delete();
      tail_m = e_mis ? (htag + 1) % 8 : htag;
    end else begin
      if (e_ret) void'(q.pop_front());
      if (iv && e_ready) begin
        q.push_back('{tag: tail_m, kind: k, dest: d, val: 0, done: 0, exc: 0, mis: 0});
        tail_m = (tail_m + 1) % 8;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic issue(int k, int d);
    step(1, k, d, 0, 0, 0, 0, 0);
  endtask
  task automatic comp(int t, int v, bit e, bit m);
    step(0, 0, 0, 1, t, v, e, m);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iss_valid = 0; iss_kind = 0; iss_dest = 0;
    cmp_valid = 0; cmp_tag = 0; cmp_value = 0; cmp_exc = 0; cmp_mispred = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    vectors++;
    chk("R1", "iss_ready", iss_ready, 1);
    chk("R1", "iss_tag", iss_tag, 0);
    chk("R1", "full", full, 0);
    chk("R1", "ret_valid", ret_valid, 0);
    chk("R1", "flush", flush, 0);
    chk("R1", "flush_exc", flush_exc, 0);
    @(negedge clk);

    // R2 R4 R5: in-order retirement of out-of-order completions
    issue(0, 1); issue(1, 2); issue(0, 3);
    comp(2, 30, 0, 0); idle(1);
    comp(0, 10, 0, 0); comp(1, 20, 0, 0);
    idle(4);

    // R6: completions to tags that are not outstanding
    comp(5, 99, 0, 0); idle(1);
    issue(2, 9);
    comp(6, 77, 0, 0); idle(2);
    comp(3, 33, 0, 0); idle(2);

    // R3 R2: fill, stall, wrap, drain in reverse order
    for (int i = 0; i < 9; i++) issue(i % 3, 10 + i);
    for (int i = 0; i < 8; i++) comp((4 + 7 - i) % 8, 100 + i, 0, 0);
    idle(10);

    // R7 R9 R10: fault at the head, younger slots already complete
    issue(1, 7); issue(0, 8); issue(2, 9);
    comp(6, 60, 0, 0); comp(5, 50, 0, 0); comp(4, 40, 1, 0);
    issue(0, 4);
    idle(1);
    issue(0, 12); comp(4, 44, 0, 0); idle(2);

    // R8 R10: correctly predicted branch, then mispredicted branch
    issue(3, 0); comp(5, 5, 0, 0); idle(2);
    issue(3, 0); issue(0, 13); issue(1, 14);
    comp(7, 70, 0, 0); comp(0, 80, 0, 0);
    comp(6, 66, 0, 1);
    issue(0, 15);
    idle(1);
    issue(0, 16); comp(7, 71, 0, 0); idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule